// File: doc/BRIEF.md
# Reply Header Swap and Output Merge

This block produces the single outgoing 32-bit word stream of a packet-processing module. It has three sources. The first is a stream of non-UDP packets, which are forwarded untouched. The second is a stream of program packets, which are echoed back to their sender. The third is a completed data packet, which a processor has finished with and which is read word by word from a banked data memory. A new source is chosen only at a packet boundary, by fixed priority. Once a packet has started, it runs to its last word.

Every echoed or completed packet leaves with its IP source and destination addresses exchanged and its UDP source and destination ports exchanged, so the reply goes back to its sender. The two addresses sit in adjacent header words. The block exchanges them using a one-word holding register, and the port word has its two halves exchanged. A completed packet is fetched only when its requester holds `done_req` high and the store logic shows, on `wr_grant`, that no new data packet is being written. `done_bank` and `done_last` must stay stable while `done_req` is high. Once the last word has been handed on, a one-cycle `bank_free` pulse releases the bank, and the requester then drops `done_req`. Checksums and lengths are never changed. Swapped packets must be at least six words long.

Top module: `reply_merge_top`

## Requirements
- R1: A packet taken from the pass stream leaves with every word, `sop` and `eop` exactly as received, and with no field exchanged. This includes a one-word packet.
- R2: An echoed program packet keeps its length and its `sop`/`eop` marking. Every word other than words 3, 4 and 5 is unchanged (word 0 is the word carrying `sop`).
- R3: For echoed and completed packets, output word 3 equals input word 4 and output word 4 equals input word 3, so the IP addresses are exchanged.
- R4: For echoed and completed packets, output word 5 carries input bits [15:0] in bits [31:16] and input bits [31:16] in bits [15:0], so the UDP ports are exchanged.
- R5: When the block is idle and several sources are waiting, the pass stream wins over the echo stream, and the echo stream wins over the completed packet. Only the chosen stream sees its ready high.
- R6: After the first word of a packet is accepted, the output carries only that packet's words, in order, up to its `eop` word.
- R7: A completed packet fetch starts only in a cycle where `done_req` is high and `wr_grant` is low. While `wr_grant` stays high, no memory read is issued and nothing from that packet is output.
- R8: A completed packet is read from address {`done_bank`, index} for index 0 up to `done_last`, in order. Read data returns one cycle after `mem_rd_en`. The output marks index 0 with `sop` and index `done_last` with `eop`.
- R9: `bank_free` is high for exactly one cycle per completed packet, in the cycle after its last word is handed to the output stage.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_sop` and `out_eop` hold their values.
- R11: After reset, `out_valid`, `bank_free` and `mem_rd_en` are low until a source presents work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pt_valid | input | 1 | Pass stream word valid |
| pt_data | input | 32 | Pass stream word |
| pt_sop | input | 1 | Pass stream first word |
| pt_eop | input | 1 | Pass stream last word |
| pt_ready | output | 1 | Pass stream word taken |
| ec_valid | input | 1 | Echo stream word valid |
| ec_data | input | 32 | Echo stream word |
| ec_sop | input | 1 | Echo stream first word |
| ec_eop | input | 1 | Echo stream last word |
| ec_ready | output | 1 | Echo stream word taken |
| done_req | input | 1 | A completed packet waits in memory |
| done_bank | input | 2 | Bank holding the completed packet |
| done_last | input | 4 | Index of the completed packet's last word |
| wr_grant | input | 1 | Store logic is writing a new data packet |
| mem_rd_en | output | 1 | Data memory read strobe |
| mem_rd_addr | output | 6 | Data memory read address {bank, index} |
| mem_rd_data | input | 32 | Data memory read word, one cycle after the strobe |
| bank_free | output | 1 | One-cycle release of the completed bank |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word |
| out_sop | output | 1 | Output first word |
| out_eop | output | 1 | Output last word |
| out_ready | input | 1 | Output word taken |

## Verification
A stream word taken at a clock edge appears on the output register at that same edge and is visible in the following cycle. The exception is the address pair. The source address word produces no output. The destination word appears one cycle later, and the held source word follows in the next cycle while the inputs are stalled. A completed packet raises `mem_rd_en` in the cycle its fetch starts. Its word is registered two edges later and reaches the output one edge after that. `bank_free` rises at the edge that hands the last word on. The bench drives inputs at the falling edge and samples ready one time unit later. It samples outputs two time units after the falling edge, so every check sees the value produced by the preceding rising edge. It compares whole packets against a queue of expected words, built beforehand from the requirements.

// File: rtl/reply_pkg.sv
// Shared types for the reply merge block.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package reply_pkg;

    // Which input currently owns the output stream
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PASS = 2'd1,
        SRC_ECHO = 2'd2,
        SRC_DONE = 2'd3
    } src_e;

    // Reader state for completed packets
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_WAIT = 2'd1,
        RD_HOLD = 2'd2,
        RD_COOL = 2'd3
    } rd_state_e;

endpackage

// File: rtl/reply_mem_reader.sv
// Turns one completed packet in banked data memory into a word stream.
// Fetch starts when done_req is high and wr_grant is low. One read is in
// flight at a time; each word is registered before it is offered. After the
// last word is taken a one-cycle bank_free pulse is raised, followed by a
// cool-down cycle so the requester can drop done_req.
// Assumes: done_bank and done_last are stable while done_req is high;
// read data returns one cycle after the read strobe.
module reply_mem_reader #(
    parameter int DW     = 32,
    parameter int BANK_W = 2,
    parameter int WORD_W = 4,
    localparam int AW    = BANK_W + WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_req,
    input  logic [BANK_W-1:0] done_bank,
    input  logic [WORD_W-1:0] done_last,
    input  logic              wr_grant,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic [DW-1:0]     mem_rd_data,
    output logic              bank_free,
    output logic              md_valid,
    output logic [DW-1:0]     md_data,
    output logic              md_sop,
    output logic              md_eop,
    input  logic              md_ready
);
    import reply_pkg::*;

    rd_state_e         state;
    logic [WORD_W-1:0] cur;
    logic [WORD_W-1:0] nxt;
    logic [DW-1:0]     data_q;
    logic              start;
    logic              last;
    logic              adv;

    // Decode the fetch start and the next-word advance
    always_comb begin
        last  = (cur == done_last);
        nxt   = cur + WORD_W'(1);
        start = (state == RD_IDLE) && done_req && !wr_grant;
        adv   = (state == RD_HOLD) && md_ready && !last;
    end

    // Memory read port
    always_comb begin
        mem_rd_en   = start || adv;
        mem_rd_addr = {done_bank, (start ? '0 : nxt)};
    end

    // Word offered to the arbiter
    always_comb begin
        md_valid = (state == RD_HOLD);
        md_data  = data_q;
        md_sop   = (cur == '0);
        md_eop   = last;
    end

    // Reader state, word index and data register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RD_IDLE;
            cur    <= '0;
            data_q <= '0;
        end else begin
            case (state)
                RD_IDLE: if (start) begin
                    cur   <= '0;
                    state <= RD_WAIT;
                end
                RD_WAIT: begin
                    data_q <= mem_rd_data;
                    state  <= RD_HOLD;
                end
                RD_HOLD: if (md_ready) begin
                    if (last) begin
                        state <= RD_COOL;
                    end else begin
                        cur   <= nxt;
                        state <= RD_WAIT;
                    end
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

    // One-cycle bank release after the last word is handed on
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_free <= 1'b0;
        end else begin
            bank_free <= (state == RD_HOLD) && md_ready && last;
        end
    end

endmodule

// File: rtl/reply_arbiter.sv
// Chooses which of three word streams feeds the swap stage. The choice is
// made only while no packet is open: pass beats echo beats completed.
// The winner is held until its eop word is accepted.
// Assumes: each source raises valid first on a sop word.
module reply_arbiter #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pt_valid,
    input  logic [DW-1:0] pt_data,
    input  logic          pt_sop,
    input  logic          pt_eop,
    output logic          pt_ready,
    input  logic          ec_valid,
    input  logic [DW-1:0] ec_data,
    input  logic          ec_sop,
    input  logic          ec_eop,
    output logic          ec_ready,
    input  logic          md_valid,
    input  logic [DW-1:0] md_data,
    input  logic          md_sop,
    input  logic          md_eop,
    output logic          md_ready,
    output logic          s_valid,
    output logic [DW-1:0] s_data,
    output logic          s_sop,
    output logic          s_eop,
    output logic          s_swap,
    input  logic          s_ready
);
    import reply_pkg::*;

    logic busy;
    src_e held;
    src_e pick;
    src_e sel;
    logic acc;

    // Fixed priority choice among waiting sources
    always_comb begin
        if (pt_valid)      pick = SRC_PASS;
        else if (ec_valid) pick = SRC_ECHO;
        else if (md_valid) pick = SRC_DONE;
        else               pick = SRC_NONE;
        sel = busy ? held : pick;
    end

    // Route the owning source to the swap stage
    always_comb begin
        s_valid = 1'b0;
        s_data  = '0;
        s_sop   = 1'b0;
        s_eop   = 1'b0;
        case (sel)
            SRC_PASS: begin
                s_valid = pt_valid; s_data = pt_data; s_sop = pt_sop; s_eop = pt_eop;
            end
            SRC_ECHO: begin
                s_valid = ec_valid; s_data = ec_data; s_sop = ec_sop; s_eop = ec_eop;
            end
            SRC_DONE: begin
                s_valid = md_valid; s_data = md_data; s_sop = md_sop; s_eop = md_eop;
            end
            default: ;
        endcase
        s_swap   = (sel == SRC_ECHO) || (sel == SRC_DONE);
        pt_ready = s_ready && (sel == SRC_PASS);
        ec_ready = s_ready && (sel == SRC_ECHO);
        md_ready = s_ready && (sel == SRC_DONE);
        acc      = s_valid && s_ready;
    end

    // Hold the grant from the first accepted word to the eop word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            held <= SRC_NONE;
        end else if (acc) begin
            busy <= !s_eop;
            held <= sel;
        end
    end

endmodule

// File: rtl/reply_swap_stage.sv
// Output register with in-flight header rewrite. For swapped packets the
// source address word is parked in a holding register and produces no
// output. The destination word is emitted in its place, then the parked
// word is emitted while the input is stalled. The port word has its halves
// exchanged. Other words pass unchanged.
// Words stay stable on the output while out_ready is low.
// Assumes: swapped packets are longer than PORT_OFS words; the address
// pair sits at SRC_OFS and SRC_OFS+1.
module reply_swap_stage #(
    parameter int DW       = 32,
    parameter int SRC_OFS  = 3,
    parameter int PORT_OFS = 5,
    localparam int DST_OFS = SRC_OFS + 1,
    localparam int MAX_OFS = (PORT_OFS > DST_OFS) ? PORT_OFS : DST_OFS,
    localparam int CNT_W   = $clog2(MAX_OFS + 2),
    localparam int HW      = DW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_valid,
    input  logic [DW-1:0] s_data,
    input  logic          s_sop,
    input  logic          s_eop,
    input  logic          s_swap,
    output logic          s_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_sop,
    output logic          out_eop,
    input  logic          out_ready
);
    localparam logic [CNT_W-1:0] SRC_I  = CNT_W'(SRC_OFS);
    localparam logic [CNT_W-1:0] DST_I  = CNT_W'(DST_OFS);
    localparam logic [CNT_W-1:0] PORT_I = CNT_W'(PORT_OFS);
    localparam logic [CNT_W-1:0] SAT_I  = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] idx;
    logic             can_load;
    logic             pend;
    logic [DW-1:0]    h_data;
    logic             h_eop;
    logic             at_src;
    logic             at_dst;
    logic             at_port;
    logic [DW-1:0]    port_sw;
    logic             take;

    // Position of the incoming word and load permission
    always_comb begin
        idx      = s_sop ? '0 : cnt;
        can_load = !out_valid || out_ready;
        s_ready  = can_load && !pend;
        take     = s_valid && s_ready;
        at_src   = s_swap && (idx == SRC_I);
        at_dst   = s_swap && (idx == DST_I);
        at_port  = s_swap && (idx == PORT_I);
        port_sw  = {s_data[HW-1:0], s_data[DW-1:HW]};
    end

    // Word position counter within the open packet, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (take) begin
            if (s_eop)               cnt <= '0;
            else if (idx == SAT_I)   cnt <= idx;
            else                     cnt <= idx + CNT_W'(1);
        end
    end

    // Output register, parking register and pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            pend      <= 1'b0;
            h_data    <= '0;
            h_eop     <= 1'b0;
        end else if (can_load) begin
            if (pend) begin
                out_valid <= 1'b1;
                out_data  <= h_data;
                out_sop   <= 1'b0;
                out_eop   <= h_eop;
                pend      <= 1'b0;
            end else if (s_valid) begin
                if (at_src) begin
                    h_data    <= s_data;
                    out_valid <= 1'b0;
                end else if (at_dst) begin
                    out_valid <= 1'b1;
                    out_data  <= s_data;
                    out_sop   <= s_sop;
                    out_eop   <= 1'b0;
                    h_eop     <= s_eop;
                    pend      <= 1'b1;
                end else begin
                    out_valid <= 1'b1;
                    out_data  <= at_port ? port_sw : s_data;
                    out_sop   <= s_sop;
                    out_eop   <= s_eop;
                end
            end else begin
                out_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/reply_merge_top.sv
// Merges pass-through, echoed program and completed data packets onto one
// output stream. Replies have their IP addresses and UDP ports exchanged.
// Assumes: data is DW bits wide with the ports in one word; header offsets
// are counted from the sop word.
module reply_merge_top #(
    parameter int DW       = 32,
    parameter int BANK_W   = 2,
    parameter int WORD_W   = 4,
    parameter int SRC_OFS  = 3,
    parameter int PORT_OFS = 5,
    localparam int AW      = BANK_W + WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pt_valid,
    input  logic [DW-1:0]     pt_data,
    input  logic              pt_sop,
    input  logic              pt_eop,
    output logic              pt_ready,
    input  logic              ec_valid,
    input  logic [DW-1:0]     ec_data,
    input  logic              ec_sop,
    input  logic              ec_eop,
    output logic              ec_ready,
    input  logic              done_req,
    input  logic [BANK_W-1:0] done_bank,
    input  logic [WORD_W-1:0] done_last,
    input  logic              wr_grant,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic [DW-1:0]     mem_rd_data,
    output logic              bank_free,
    output logic              out_valid,
    output logic [DW-1:0]     out_data,
    output logic              out_sop,
    output logic              out_eop,
    input  logic              out_ready
);
    logic          md_valid;
    logic [DW-1:0] md_data;
    logic          md_sop;
    logic          md_eop;
    logic          md_ready;
    logic          s_valid;
    logic [DW-1:0] s_data;
    logic          s_sop;
    logic          s_eop;
    logic          s_swap;
    logic          s_ready;

    reply_mem_reader #(.DW(DW), .BANK_W(BANK_W), .WORD_W(WORD_W)) u_reader (
        .clk(clk), .rst_n(rst_n),
        .done_req(done_req), .done_bank(done_bank), .done_last(done_last),
        .wr_grant(wr_grant),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .bank_free(bank_free),
        .md_valid(md_valid), .md_data(md_data), .md_sop(md_sop), .md_eop(md_eop),
        .md_ready(md_ready)
    );

    reply_arbiter #(.DW(DW)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .pt_valid(pt_valid), .pt_data(pt_data), .pt_sop(pt_sop), .pt_eop(pt_eop),
        .pt_ready(pt_ready),
        .ec_valid(ec_valid), .ec_data(ec_data), .ec_sop(ec_sop), .ec_eop(ec_eop),
        .ec_ready(ec_ready),
        .md_valid(md_valid), .md_data(md_data), .md_sop(md_sop), .md_eop(md_eop),
        .md_ready(md_ready),
        .s_valid(s_valid), .s_data(s_data), .s_sop(s_sop), .s_eop(s_eop),
        .s_swap(s_swap), .s_ready(s_ready)
    );

    reply_swap_stage #(.DW(DW), .SRC_OFS(SRC_OFS), .PORT_OFS(PORT_OFS)) u_swap (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_data(s_data), .s_sop(s_sop), .s_eop(s_eop),
        .s_swap(s_swap), .s_ready(s_ready),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
        .out_eop(out_eop), .out_ready(out_ready)
    );

endmodule

// File: rtl/reply_merge_chk.sv
// Port-level properties of the reply merge block, bound to its top.
// Assumes: synchronous active-low reset held from time zero.
module reply_merge_chk #(
    parameter int DW     = 32,
    parameter int WORD_W = 4,
    parameter int AW     = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data,
    input logic          out_sop,
    input logic          out_eop,
    input logic          bank_free,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_rd_addr,
    input logic          done_req,
    input logic          wr_grant,
    input logic          pt_ready,
    input logic          ec_ready
);
    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_sop) && $stable(out_eop));

    // R9
    free_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_free |=> !bank_free);

    // R7
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en && (mem_rd_addr[WORD_W-1:0] == '0) |-> done_req && !wr_grant);

    // R5
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pt_ready && ec_ready));

    // R11
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !bank_free);

endmodule

bind reply_merge_top reply_merge_chk #(.DW(DW), .WORD_W(WORD_W), .AW(AW)) i_chk (
    .clk(clk), .rst_n(rst_n),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop),
    .bank_free(bank_free), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .done_req(done_req), .wr_grant(wr_grant),
    .pt_ready(pt_ready), .ec_ready(ec_ready)
);

// File: tb/test_reply_merge_top.sv
module test_reply_merge_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pt_valid = 1'b0, pt_sop = 1'b0, pt_eop = 1'b0;
    logic [31:0] pt_data = '0;
    logic        ec_valid = 1'b0, ec_sop = 1'b0, ec_eop = 1'b0;
    logic [31:0] ec_data = '0;
    logic        pt_ready, ec_ready;
    logic        done_req = 1'b0;
    logic [1:0]  done_bank = '0;
    logic [3:0]  done_last = '0;
    logic        wr_grant = 1'b0;
    logic        mem_rd_en;
    logic [5:0]  mem_rd_addr;
    logic [31:0] mem_rd_data;
    logic        bank_free;
    logic        out_valid, out_sop, out_eop;
    logic [31:0] out_data;
    logic        out_ready = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    reply_merge_top i_reply_merge_top (
        .clk(clk), .rst_n(rst_n),
        .pt_valid(pt_valid), .pt_data(pt_data), .pt_sop(pt_sop), .pt_eop(pt_eop),
        .pt_ready(pt_ready),
        .ec_valid(ec_valid), .ec_data(ec_data), .ec_sop(ec_sop), .ec_eop(ec_eop),
        .ec_ready(ec_ready),
        .done_req(done_req), .done_bank(done_bank), .done_last(done_last),
        .wr_grant(wr_grant),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .bank_free(bank_free),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
        .out_eop(out_eop), .out_ready(out_ready)
    );

    // Data memory model with one-cycle read latency
    logic [31:0] bmem [64];
    always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= bmem[mem_rd_addr];

    int          errors = 0, checks = 0;
    logic [31:0] pt_buf [16];
    logic [31:0] ec_buf [16];
    logic [33:0] exp_q [$];
    string       tag_q [$];
    int          beats = 0, rd_cnt = 0, free_cnt = 0;
    int          stall_n = 0, stall_err = 0;
    bit          rnd_rdy = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Raw input word i of a packet from source 0 pass, 1 echo, 2 memory bank
    function automatic logic [31:0] raw_word(input int src, input int i, input int bank);
        if (src == 0) return pt_buf[i];
        if (src == 1) return ec_buf[i];
        return bmem[bank*16 + i];
    endfunction

    // Expected output word per R1..R4 and R8
    function automatic logic [31:0] exp_word(input int src, input int i, input int bank);
        logic [31:0] w;
        if (src == 0) return raw_word(src, i, bank);
        if (i == 3) return raw_word(src, 4, bank);
        if (i == 4) return raw_word(src, 3, bank);
        w = raw_word(src, i, bank);
        if (i == 5) return {w[15:0], w[31:16]};
        return w;
    endfunction

    task automatic push_exp(input int src, input int n, input int bank, input string tag);
        for (int i = 0; i < n; i++)
            exp_q.push_back({(i == 0), (i == n-1), exp_word(src, i, bank)});
        tag_q.push_back(tag);
    endtask

    task automatic fill(input int src, input int n);
        for (int i = 0; i < n; i++) begin
            if (src == 0) pt_buf[i] = $urandom;
            else          ec_buf[i] = $urandom;
        end
    endtask

    task automatic send_stream(input int which, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (which == 0) begin
                pt_valid = 1'b1; pt_data = pt_buf[i]; pt_sop = (i == 0); pt_eop = (i == n-1);
            end else begin
                ec_valid = 1'b1; ec_data = ec_buf[i]; ec_sop = (i == 0); ec_eop = (i == n-1);
            end
            #1;
            while (!(which == 0 ? pt_ready : ec_ready)) begin
                @(negedge clk); #1;
            end
        end
        @(negedge clk);
        if (which == 0) pt_valid = 1'b0; else ec_valid = 1'b0;
    endtask

    task automatic run_mem(input int bank, input int last);
        @(negedge clk);
        done_bank = 2'(bank); done_last = 4'(last); done_req = 1'b1;
        @(negedge clk);
        while (!bank_free) @(negedge clk);
        done_req = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Random output back-pressure
    initial forever begin
        @(negedge clk);
        out_ready = rnd_rdy ? ($urandom % 4 != 0) : 1'b1;
    end

    // Output monitor: packet scoreboard, stall stability, read and free counts
    initial begin
        logic [33:0] e, bad_act, bad_exp, pd;
        bit          pkt_bad = 1'b0, prev_stall = 1'b0;
        string       tg;
        forever begin
            @(negedge clk); #2;
            if (rst_n) begin
                if (prev_stall) begin
                    stall_n++;
                    if (!out_valid || {out_sop, out_eop, out_data} != pd) stall_err++;
                end
                prev_stall = out_valid && !out_ready;
                pd = {out_sop, out_eop, out_data};
                if (mem_rd_en) rd_cnt++;
                if (bank_free) free_cnt++;
                if (out_valid && out_ready) begin
                    beats++;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R6", "unexpected output word", int'(out_data), 0);
                    end else begin
                        e = exp_q.pop_front();
                        if ({out_sop, out_eop, out_data} != e && !pkt_bad) begin
                            pkt_bad = 1'b1; bad_act = {out_sop, out_eop, out_data}; bad_exp = e;
                        end
                        if (e[32]) begin
                            tg = tag_q.pop_front();
                            checks++;
                            if (pkt_bad) begin
                                errors++;
                                $display("FAIL %s packet word: actual=%h expected=%h", tg, bad_act, bad_exp);
                            end
                            pkt_bad = 1'b0;
                        end
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R6 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n, src, rd0, b0, f0;
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) bmem[i] = $urandom;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        // R11 reset state
        check(!out_valid && !bank_free && !mem_rd_en, "R11", "idle after reset",
              int'({out_valid, bank_free, mem_rd_en}), 0);
        rnd_rdy = 1'b1;

        // R1 pass stream, including a one-word packet
        for (int k = 0; k < 3; k++) begin
            n = (k == 0) ? 1 : 4 + $urandom % 13;
            fill(0, n); push_exp(0, n, 0, "R1");
            send_stream(0, n); drain();
        end

        // R2 R3 R4 echo stream, including the shortest legal packet
        for (int k = 0; k < 3; k++) begin
            n = (k == 0) ? 6 : 7 + $urandom % 10;
            fill(1, n); push_exp(1, n, 0, "R2 R3 R4");
            send_stream(1, n); drain();
        end

        // R7 fetch held off while the store logic writes
        f0 = free_cnt;
        @(negedge clk); wr_grant = 1'b1;
        push_exp(2, 10, 1, "R8 R3 R4");
        fork run_mem(1, 9); join_none
        rd0 = rd_cnt; b0 = beats;
        repeat (40) @(negedge clk);
        check(rd_cnt == rd0, "R7", "reads while wr_grant high", rd_cnt - rd0, 0);
        check(beats == b0, "R7", "words while wr_grant high", beats - b0, 0);
        wr_grant = 1'b0;
        wait fork;
        drain();
        // R9 exactly one release per completed packet
        check(free_cnt == f0 + 1, "R9", "bank_free pulses", free_cnt - f0, 1);

        // R5 R6 all three sources waiting at once
        fill(0, 8); fill(1, 9);
        push_exp(0, 8, 0, "R5 R6");
        push_exp(1, 9, 0, "R5 R6");
        push_exp(2, 12, 2, "R5 R6");
        fork
            send_stream(0, 8);
            send_stream(1, 9);
            run_mem(2, 11);
        join
        drain();

        // Random mix of sources, lengths and banks
        for (int k = 0; k < 12; k++) begin
            src = $urandom % 3;
            if (src == 2) begin
                int bk, ls;
                bk = $urandom % 4; ls = 6 + $urandom % 10;
                f0 = free_cnt;
                push_exp(2, ls + 1, bk, "R8");
                run_mem(bk, ls); drain();
                check(free_cnt == f0 + 1, "R9", "bank_free pulses", free_cnt - f0, 1);
            end else begin
                n = 6 + $urandom % 11;
                fill(src, n);
                push_exp(src, n, 0, src == 0 ? "R1" : "R2 R3 R4");
                send_stream(src, n); drain();
            end
        end

        // R10 stalled words held
        check(stall_err == 0 && stall_n > 0, "R10", "stall mismatches", stall_err, 0);
        check(exp_q.size() == 0, "R6", "words left unsent", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule